// File: doc/BRIEF.md
# Coprocessor Host Register Window

This block is the host-facing register window of a graphics coprocessor. A byte-wide host bus reaches sixteen 16-bit general registers, a status word, a program bank byte, a clock select bit, a plot mode register and a fixed version byte. A 16-bit register is written in two steps. The low byte goes into one shared staging latch. The high-byte write then commits both bytes together. Committing the high byte of the last register, R15, starts the coprocessor.

Once the coprocessor is running, the window locks. Only the status word, the version byte and the mode register stay reachable. The block also provides the start/stop control for the core. When the core signals completion, the block raises an interrupt to the host, and that interrupt is cleared by reading the upper status byte. The block drives a stall line that holds the core while it is stopped, and also while it waits for a memory grant the host has not yet given. Instruction execution and cache contents are outside this block.

Top module: `hrw_top`

## Requirements
- R1: The host address is ANDed with 0x33FF before any decode, so a mirror such as 0x7003 reaches 0x3003. A read of an address that maps to nothing returns 0x00.
- R2: Register Rn has its low byte at 0x3000+2n and its high byte at 0x3001+2n. A low-byte write only loads one latch shared by all registers, and the register keeps its old value. A high-byte write stores {written byte, latch} into Rn.
- R3: A write to 0x301F commits R15 and sets the running flag.
- R4: Committing R14 raises `rom_pend` for exactly 6 cycles when clock select (0x3039 bit 0) is 0, and for exactly 5 cycles when it is 1.
- R5: While running, host reads return 0x00 except at 0x3030, 0x3031 and 0x303B.
- R6: While running, host writes are ignored except at 0x3030 and 0x303A.
- R7: A write to 0x3030 loads zero, carry, sign, overflow and running from bits 1, 2, 3, 4 and 5. Reading 0x3030 returns those flags in the same bit positions, with bits 0, 6 and 7 reading as 0.
- R8: A `core_done` pulse clears running and sets the interrupt flag; `irq` follows that flag. Reading 0x3031 returns the flag in bit 7 (other bits 0) and clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: Reading 0x303B returns 0x04. The program bank at 0x3034 keeps only bits 6:0, and bit 7 reads back as 0.
- R10: In the mode register at 0x303A, bits 1:0 select the pixel depth on `pix_bpp`: 0 gives 2, 1 or 2 gives 4, and 3 gives 8. `scr_height` is {bit 5, bit 2}. Bit 3 grants RAM access and bit 4 grants ROM access.
- R11: `core_stall` is high while not running, or while `core_ram_req` is high without the RAM grant, or while `core_rom_req` is high without the ROM grant. It drops in the cycle after the missing grant bit is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 16 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe, which has side effects |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational, 0 when not reading |
| core_done | input | 1 | Core finished pulse |
| core_ram_req | input | 1 | Core is waiting on a RAM access |
| core_rom_req | input | 1 | Core is waiting on a ROM access |
| running | output | 1 | Running flag |
| irq | output | 1 | Interrupt to host |
| rom_pend | output | 1 | ROM read pending after an R14 commit |
| core_stall | output | 1 | Holds the core |
| pix_bpp | output | 4 | Pixel depth in bits |
| scr_height | output | 2 | Screen height code |
| clk_fast | output | 1 | Clock select bit |

## Verification
The hardest case to reach is a stall caused by a missing grant. That needs three things at once: the core running, a memory request asserted, and the matching grant clear. Every earlier grant write must also have passed through the lock. The stimulus first writes grants of zero while the core is stopped. It then starts the core through the status word, raises one request at a time, and writes the grant through the mode register, which stays writable while running. After the commit edge it checks that the stall line dropped. A similar path checks the locked window: stores and bank writes made while running must read back unchanged once the core is stopped.

// File: rtl/hrw_pkg.sv
// Shared constants and types for the host register window.
// Assumes a byte-wide host bus and 16-bit addresses.
package hrw_pkg;
    localparam logic [15:0] ADDR_MASK  = 16'h33FF;
    localparam logic [15:0] REG_BASE   = 16'h3000;
    localparam logic [15:0] A_FLAG_LO  = 16'h3030;
    localparam logic [15:0] A_FLAG_HI  = 16'h3031;
    localparam logic [15:0] A_PBANK    = 16'h3034;
    localparam logic [15:0] A_CLKSEL   = 16'h3039;
    localparam logic [15:0] A_MODE     = 16'h303A;
    localparam logic [15:0] A_VERSION  = 16'h303B;
    localparam logic [7:0]  VERSION_ID = 8'h04;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_REG, SEL_FLO, SEL_FHI,
        SEL_PBANK, SEL_CLK, SEL_MODE, SEL_VER
    } sel_e;

    typedef struct packed {
        logic       rom_gnt;
        logic       ram_gnt;
        logic [1:0] height;
        logic [1:0] depth;
    } mode_t;
endpackage

// File: rtl/hrw_decode.sv
// Address decoder: masks the host address and classifies the target.
// Assumes the register region is 2*NREG bytes starting at REG_BASE.
module hrw_decode
    import hrw_pkg::*;
#(
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic [15:0]   host_addr,
    output sel_e          sel,
    output logic [IW-1:0] reg_idx,
    output logic          hi_byte
);
    logic [15:0] masked;
    logic [15:0] offset;

    // Masking, offset into the register region and target selection
    always_comb begin
        masked  = host_addr & ADDR_MASK;
        offset  = masked - REG_BASE;
        reg_idx = offset[IW:1];
        hi_byte = offset[0];
        if (masked >= REG_BASE && offset < 16'(2 * NREG)) sel = SEL_REG;
        else begin
            case (masked)
                A_FLAG_LO: sel = SEL_FLO;
                A_FLAG_HI: sel = SEL_FHI;
                A_PBANK:   sel = SEL_PBANK;
                A_CLKSEL:  sel = SEL_CLK;
                A_MODE:    sel = SEL_MODE;
                A_VERSION: sel = SEL_VER;
                default:   sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/hrw_regfile.sv
// General register file written through a shared low-byte latch.
// Assumes wr_lo/wr_hi are already qualified by the access lock.
module hrw_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [IW-1:0] idx,
    input  logic          hi_sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_byte
);
    logic [DW-1:0]   latch_q;
    logic [2*DW-1:0] regs [NREG];

    // Low-byte staging latch
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_q <= '0;
        else if (wr_lo) latch_q <= wdata;
    end

    // One register per entry, committed on a high-byte write
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                        regs[g] <= '0;
            else if (wr_hi && idx == IW'(g))   regs[g] <= {wdata, latch_q};
        end
    end

    // Byte selection for readback
    always_comb rd_byte = hi_sel ? regs[idx][2*DW-1:DW] : regs[idx][DW-1:0];
endmodule

// File: rtl/hrw_ctrl.sv
// Run control, status flags, interrupt, bank, clock select, mode register,
// ROM pending timer and core stall. Assumes wr_ok/rd_ok are lock-qualified.
module hrw_ctrl
    import hrw_pkg::*;
#(
    parameter int DLY_SLOW = 6,
    parameter int DLY_FAST = 5,
    localparam int CW = $clog2(DLY_SLOW + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ok,
    input  logic       rd_ok,
    input  sel_e       sel,
    input  logic [7:0] wdata,
    input  logic       commit_r14,
    input  logic       commit_r15,
    input  logic       core_done,
    input  logic       core_ram_req,
    input  logic       core_rom_req,
    output logic       running,
    output logic       irq,
    output logic       rom_pend,
    output logic       core_stall,
    output logic       clk_fast,
    output logic [6:0] pbank,
    output mode_t      mode,
    output logic [3:0] pix_bpp,
    output logic [7:0] flag_lo,
    output logic [7:0] flag_hi
);
    logic          f_zero, f_carry, f_sign, f_ovf;
    logic [CW-1:0] rom_cnt;

    // Running flag: core completion beats host start/stop
    always_ff @(posedge clk) begin
        if (!rst_n)                          running <= 1'b0;
        else if (core_done)                  running <= 1'b0;
        else if (wr_ok && sel == SEL_FLO)    running <= wdata[5];
        else if (commit_r15)                 running <= 1'b1;
    end

    // Arithmetic flags loaded from the status write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {f_zero, f_carry, f_sign, f_ovf} <= '0;
        end else if (wr_ok && sel == SEL_FLO) begin
            f_zero  <= wdata[1];
            f_carry <= wdata[2];
            f_sign  <= wdata[3];
            f_ovf   <= wdata[4];
        end
    end

    // Interrupt flag: set by completion, cleared by reading the upper status byte
    always_ff @(posedge clk) begin
        if (!rst_n)                          irq <= 1'b0;
        else if (core_done)                  irq <= 1'b1;
        else if (rd_ok && sel == SEL_FHI)    irq <= 1'b0;
    end

    // Bank, clock select and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pbank    <= '0;
            clk_fast <= 1'b0;
            mode     <= '0;
        end else if (wr_ok) begin
            if (sel == SEL_PBANK) pbank    <= wdata[6:0];
            if (sel == SEL_CLK)   clk_fast <= wdata[0];
            if (sel == SEL_MODE)  mode     <= '{rom_gnt: wdata[4], ram_gnt: wdata[3],
                                                height: {wdata[5], wdata[2]},
                                                depth: wdata[1:0]};
        end
    end

    // ROM pending timer started by an R14 commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_cnt  <= '0;
            rom_pend <= 1'b0;
        end else if (commit_r14) begin
            rom_cnt  <= clk_fast ? CW'(DLY_FAST) : CW'(DLY_SLOW);
            rom_pend <= 1'b1;
        end else if (rom_cnt != '0) begin
            rom_cnt <= rom_cnt - 1'b1;
            if (rom_cnt == CW'(1)) rom_pend <= 1'b0;
        end
    end

    // Depth decode, status bytes and stall
    always_comb begin
        case (mode.depth)
            2'd0:    pix_bpp = 4'd2;
            2'd3:    pix_bpp = 4'd8;
            default: pix_bpp = 4'd4;
        endcase
        flag_lo    = {2'b00, running, f_ovf, f_sign, f_carry, f_zero, 1'b0};
        flag_hi    = {irq, 7'b0};
        core_stall = !running || (core_ram_req && !mode.ram_gnt)
                              || (core_rom_req && !mode.rom_gnt);
    end
endmodule

// File: rtl/hrw_top.sv
// Host register window top: decode, access lock, read mux and wiring.
// Assumes host_rd/host_wr are single-cycle qualified strobes.
module hrw_top
    import hrw_pkg::*;
#(
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] host_addr,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        core_done,
    input  logic        core_ram_req,
    input  logic        core_rom_req,
    output logic        running,
    output logic        irq,
    output logic        rom_pend,
    output logic        core_stall,
    output logic [3:0]  pix_bpp,
    output logic [1:0]  scr_height,
    output logic        clk_fast
);
    sel_e          sel;
    logic [IW-1:0] reg_idx;
    logic          hi_byte;
    logic          wr_ok, rd_ok, wr_lo, wr_hi, commit_r14, commit_r15;
    logic [7:0]    reg_byte, flag_lo, flag_hi;
    logic [6:0]    pbank;
    mode_t         mode;

    hrw_decode #(.NREG(NREG)) i_dec (
        .host_addr(host_addr), .sel(sel), .reg_idx(reg_idx), .hi_byte(hi_byte)
    );

    // Access lock and commit strobes
    always_comb begin
        wr_ok = host_wr && (!running || sel == SEL_FLO || sel == SEL_MODE);
        rd_ok = host_rd && (!running || sel == SEL_FLO || sel == SEL_FHI || sel == SEL_VER);
        wr_lo = wr_ok && sel == SEL_REG && !hi_byte;
        wr_hi = wr_ok && sel == SEL_REG && hi_byte;
        commit_r14 = wr_hi && reg_idx == IW'(NREG - 2);
        commit_r15 = wr_hi && reg_idx == IW'(NREG - 1);
    end

    hrw_regfile #(.NREG(NREG), .DW(8)) i_rf (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .idx(reg_idx),
        .hi_sel(hi_byte), .wdata(host_wdata), .rd_byte(reg_byte)
    );

    hrw_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_ok(rd_ok), .sel(sel),
        .wdata(host_wdata), .commit_r14(commit_r14), .commit_r15(commit_r15),
        .core_done(core_done), .core_ram_req(core_ram_req), .core_rom_req(core_rom_req),
        .running(running), .irq(irq), .rom_pend(rom_pend), .core_stall(core_stall),
        .clk_fast(clk_fast), .pbank(pbank), .mode(mode), .pix_bpp(pix_bpp),
        .flag_lo(flag_lo), .flag_hi(flag_hi)
    );

    // Read data multiplexer, zero when locked or idle
    always_comb begin
        host_rdata = 8'h00;
        if (rd_ok) begin
            case (sel)
                SEL_REG:   host_rdata = reg_byte;
                SEL_FLO:   host_rdata = flag_lo;
                SEL_FHI:   host_rdata = flag_hi;
                SEL_PBANK: host_rdata = {1'b0, pbank};
                SEL_VER:   host_rdata = VERSION_ID;
                default:   host_rdata = 8'h00;
            endcase
        end
        scr_height = mode.height;
    end
endmodule

// File: rtl/hrw_checker.sv
// Property checker for hrw_top, attached by bind. Decodes addresses itself.
module hrw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] host_addr,
    input logic        host_wr,
    input logic        host_rd,
    input logic [7:0]  host_rdata,
    input logic        core_done,
    input logic        running,
    input logic        irq,
    input logic        rom_pend,
    input logic        core_stall
);
    logic [15:0] ma;
    always_comb ma = host_addr & 16'h33FF;

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && ma == 16'h301F && !running && !core_done) |=> running);

    assert_rom_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && ma == 16'h301D && !running) |=> rom_pend);

    assert_locked_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && running && ma != 16'h3030 && ma != 16'h3031 && ma != 16'h303B)
        |-> host_rdata == 8'h00);

    assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> (irq && !running));

    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && ma == 16'h3031 && !core_done) |=> !irq);

    assert_version_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && ma == 16'h303B) |-> host_rdata == 8'h04);

    assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> core_stall);
endmodule

bind hrw_top hrw_checker i_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_rdata(host_rdata), .core_done(core_done),
    .running(running), .irq(irq), .rom_pend(rom_pend), .core_stall(core_stall)
);

// File: tb/test_hrw_top.sv
module test_hrw_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic [15:0] host_addr = '0;
    logic        host_wr = 0, host_rd = 0;
    logic [7:0]  host_wdata = '0, host_rdata;
    logic        core_done = 0, core_ram_req = 0, core_rom_req = 0;
    logic        running, irq, rom_pend, core_stall, clk_fast;
    logic [3:0]  pix_bpp;
    logic [1:0]  scr_height;
    int checks = 0, errors = 0;

    hrw_top i_hrw_top (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a; host_rd = 1; #1 d = host_rdata;
        @(negedge clk); host_rd = 0;
    endtask

    task automatic t_reset;
        chk("R11 reset stall", core_stall, 1);
        chk("R3 reset running", running, 0);
        chk("R8 reset irq", irq, 0);
        chk("R4 reset rom_pend", rom_pend, 0);
        chk("R10 reset bpp", pix_bpp, 2);
    endtask

    task automatic t_latch;
        logic [7:0] d;
        wr(16'h3004, 8'h34); rd(16'h3004, d); chk("R2 low write alone", d, 8'h00);
        wr(16'h3005, 8'h12); rd(16'h3004, d); chk("R2 commit low", d, 8'h34);
        rd(16'h3005, d); chk("R2 commit high", d, 8'h12);
        wr(16'h3000, 8'hAA); wr(16'h3007, 8'h55);
        rd(16'h3006, d); chk("R2 shared latch", d, 8'hAA);
        wr(16'h7002, 8'hEF); wr(16'h7003, 8'hBE);
        rd(16'h3002, d); chk("R1 mirror low", d, 8'hEF);
        rd(16'hB003, d); chk("R1 mirror high", d, 8'hBE);
        rd(16'h3020, d); chk("R1 unmapped", d, 8'h00);
    endtask

    task automatic t_flags_bank;
        logic [7:0] d;
        wr(16'h3030, 8'hDE); rd(16'h3030, d); chk("R7 flag bits", d, 8'h1E);
        wr(16'h3030, 8'h00); rd(16'h3030, d); chk("R7 flags clear", d, 8'h00);
        wr(16'h3034, 8'hFF); rd(16'h3034, d); chk("R9 bank 7 bits", d, 8'h7F);
        rd(16'h303B, d); chk("R9 version", d, 8'h04);
    endtask

    task automatic t_rom_delay(input logic fast, input int exp);
        int n = 0;
        wr(16'h3039, {7'b0, fast});
        wr(16'h301C, 8'h00); wr(16'h301D, 8'h80);
        while (rom_pend && n < 20) begin n++; @(negedge clk); end
        chk("R4 rom pending cycles", n, exp);
    endtask

    task automatic t_mode;
        wr(16'h303A, 8'h00); chk("R10 depth 0", pix_bpp, 2);
        wr(16'h303A, 8'h01); chk("R10 depth 1", pix_bpp, 4);
        wr(16'h303A, 8'h02); chk("R10 depth 2", pix_bpp, 4);
        wr(16'h303A, 8'h03); chk("R10 depth 3", pix_bpp, 8);
        wr(16'h303A, 8'h24); chk("R10 height 3", scr_height, 3);
        wr(16'h303A, 8'h20); chk("R10 height 2", scr_height, 2);
        wr(16'h303A, 8'h04); chk("R10 height 1", scr_height, 1);
        wr(16'h303A, 8'h00);
    endtask

    task automatic t_lock;
        logic [7:0] d;
        wr(16'h301E, 8'h00); wr(16'h301F, 8'h80);
        chk("R3 start on R15 commit", running, 1);
        rd(16'h3002, d); chk("R5 locked read", d, 8'h00);
        rd(16'h3030, d); chk("R5 status readable", d, 8'h20);
        rd(16'h303B, d); chk("R5 version readable", d, 8'h04);
        wr(16'h3002, 8'h11); wr(16'h3003, 8'h22); wr(16'h3034, 8'h05);
        wr(16'h3039, 8'h01); chk("R6 clock select locked", clk_fast, 0);
        wr(16'h303A, 8'h03); chk("R6 mode writable", pix_bpp, 8);
        wr(16'h3030, 8'h00); chk("R7 stop by status", running, 0);
        rd(16'h3002, d); chk("R6 reg low kept", d, 8'hEF);
        rd(16'h3003, d); chk("R6 reg high kept", d, 8'hBE);
        rd(16'h3034, d); chk("R6 bank kept", d, 8'h7F);
        rd(16'h301F, d); chk("R3 R15 value", d, 8'h80);
        wr(16'h303A, 8'h00);
    endtask

    task automatic t_stall;
        wr(16'h3030, 8'h20); chk("R11 running no req", core_stall, 0);
        @(negedge clk); core_ram_req = 1; #1 chk("R11 ram wait", core_stall, 1);
        wr(16'h303A, 8'h08); chk("R11 ram grant", core_stall, 0);
        @(negedge clk); core_rom_req = 1; #1 chk("R11 rom wait", core_stall, 1);
        wr(16'h303A, 8'h18); chk("R11 rom grant", core_stall, 0);
        core_ram_req = 0; core_rom_req = 0;
    endtask

    task automatic t_irq;
        logic [7:0] d;
        @(negedge clk); core_done = 1; @(negedge clk); core_done = 0;
        chk("R8 done stops", running, 0);
        chk("R8 done irq", irq, 1);
        rd(16'h3031, d); chk("R8 flag byte", d, 8'h80);
        chk("R8 irq cleared", irq, 0);
        rd(16'h3031, d); chk("R8 flag byte clear", d, 8'h00);
        @(negedge clk); core_done = 1; host_addr = 16'h3031; host_rd = 1;
        @(negedge clk); core_done = 0; host_rd = 0;
        chk("R8 set beats clear", irq, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_flags_bank();
        t_rom_delay(1'b0, 6);
        t_rom_delay(1'b1, 5);
        wr(16'h3039, 8'h00);
        t_mode();
        t_lock();
        t_stall();
        t_irq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule